// File: doc/BRIEF.md
# PS/2 host port controller

This block is the host end of one PS/2 port. It filters and samples the open-drain clock and data lines, assembles device-to-host frames into a one-byte receive holding register, and serialises a one-byte transmit holding register into host-to-device frames. Every frame carries a start bit of 0, eight data bits sent least significant bit first, an odd parity bit and a stop bit of 1. A host-to-device frame ends with an acknowledge bit that the device drives low. Parity and framing problems are flagged. A level interrupt is raised when the receive register is full, or when the transmit register is empty, if the matching enable is set.

Software works through four byte-wide registers: control, status, transmit and receive. The line outputs are active-high pull-down enables: a 1 on an output means that the open-drain line is pulled low. Software can hold the clock low to pause the device, or have the block hold the clock low after a transmission. A control bit soft-resets the datapath. A system with two ports instantiates the block twice.

Top module: `ps2_host_port`

## Requirements
- R1: After reset the control register is 0 and the clock line is held low. Once the line filter settles, status reads 0x0A, the interrupt is low and the data line is released. Status bits are: 0 filtered clock line, 1 clock pull-down active, 2 transmit in progress, 3 transmit register empty, 4 receive register full, 5 receive in progress, 6 parity error, 7 framing error. Register addresses are 0 control, 1 status, 2 transmit, 3 receive.
- R2: With control bit 4 (receive clock enable) set, a frame clocked in by the device is sampled on filtered falling clock edges. Its byte then appears at address 3, status bit 4 sets, and status bit 5 reads 1 while the frame is partly received.
- R3: A received frame whose data and parity bits hold an even number of ones sets status bit 6.
- R4: A received stop bit of 0 sets status bit 7. So does a transmission whose acknowledge bit is sampled as 1.
- R5: A read of address 3 clears status bits 4, 6 and 7.
- R6: With control bit 4 clear and no transmission running, the clock pull-down stays active (status bit 1) and no frame is received.
- R7: A write to address 2 is taken only while status bit 3 is set. Otherwise the held byte is kept and later sent unchanged.
- R8: With control bit 1 set and a byte held, the block pulls the clock low for at least INHIBIT_CYCLES cycles, with status bit 2 set. It then pulls data low and releases the clock, and it drives the data bits LSB first, odd parity and a released stop bit on device falling edges. Status bit 3 is set again after an acknowledged frame.
- R9: With control bit 1 clear, a held byte is not sent and the clock is not pulled low for it.
- R10: With control bit 0 set, the clock pull-down turns on when a transmission completes. It stays on until control bit 0 is cleared.
- R11: While control bit 5 is set, the receive-full, error and transmit-held states are cleared, nothing is sent and the clock is held low.
- R12: The interrupt is (status bit 4 AND control bit 3) OR (status bit 3 AND control bit 2 AND control bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at address 3) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| ps2_clk_i | input | 1 | Sensed PS/2 clock line |
| ps2_dat_i | input | 1 | Sensed PS/2 data line |
| ps2_clk_oe_o | output | 1 | Pull clock line low when 1 |
| ps2_dat_oe_o | output | 1 | Pull data line low when 1 |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with FILT_LEN of 3 and INHIBIT_CYCLES of 20. A full host-to-device exchange, including the request pulse and the acknowledge, therefore completes in a few hundred cycles. The short filter lets a modelled device clock with 8- and 12-cycle phases and still be seen cleanly on every edge. The short inhibit lets the bench measure the pull-down length exactly and run the acknowledged, unacknowledged and hold-after-send cases back to back.

// File: rtl/ps2_host_pkg.sv
package ps2_host_pkg;
    // control register bit positions
    localparam int CTRL_HOLD  = 0;
    localparam int CTRL_TXEN  = 1;
    localparam int CTRL_TXIE  = 2;
    localparam int CTRL_RXIE  = 3;
    localparam int CTRL_RXCLK = 4;
    localparam int CTRL_SRST  = 5;

    localparam int FRAME_LAST = 10;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_TXB  = 2'd2,
        ADDR_RXB  = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        TX_IDLE    = 2'd0,
        TX_INHIBIT = 2'd1,
        TX_SHIFT   = 2'd2
    } tx_state_e;

    function automatic logic odd_par(input logic [7:0] b);
        return ~(^b);
    endfunction
endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          level;
    } filt_t;

    filt_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], line_i};
        if (q.sync[1] != q.level) begin
            if (q.cnt == CW'(FILT_LEN - 1)) begin
                d.level = q.sync[1];
                d.cnt   = '0;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync  <= 2'b11;
            q.cnt   <= '0;
            q.level <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign level_o = q.level;

    // R2: the filtered level only moves to a value the synchroniser presented
    p_filt_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.level) |-> ($past(q.sync[1]) == q.level));
endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       enable_i,
    input  logic       fall_i,
    input  logic       dat_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] byte_o,
    output logic       perr_o,
    output logic       ferr_o
);
    import ps2_host_pkg::*;

    typedef struct packed {
        logic [3:0] cnt;
        logic [7:0] data;
        logic       par;
        logic       done;
        logic       perr;
        logic       ferr;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (clr_i || !enable_i) begin
            d.cnt = '0;
        end else if (fall_i) begin
            if (q.cnt == 4'd0) begin
                if (!dat_i) d.cnt = 4'd1;
            end else if (q.cnt <= 4'd8) begin
                d.data = {dat_i, q.data[7:1]};
                d.cnt  = q.cnt + 4'd1;
            end else if (q.cnt == 4'd9) begin
                d.par = dat_i;
                d.cnt = q.cnt + 4'd1;
            end else begin
                d.done = 1'b1;
                d.perr = ~(^{q.data, q.par});
                d.ferr = ~dat_i;
                d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = (q.cnt != 4'd0);
    assign done_o = q.done;
    assign byte_o = q.data;
    assign perr_o = q.perr;
    assign ferr_o = q.ferr;

    // R6: a disabled receiver holds no partial frame
    p_rx_idle_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (q.cnt == 4'd0));
    // R2: bit counter never passes the stop bit
    p_rx_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= 4'(FRAME_LAST));
    // R2: completion leaves the receiver idle
    p_rx_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.cnt == 4'd0));
endmodule

// File: rtl/ps2_tx_frame.sv
module ps2_tx_frame #(
    parameter int INHIBIT_CYCLES = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       start_i,
    input  logic [7:0] byte_i,
    input  logic       fall_i,
    input  logic       dat_i,
    output logic       busy_o,
    output logic       clk_low_o,
    output logic       dat_low_o,
    output logic       shifting_o,
    output logic       done_o,
    output logic       nack_o
);
    import ps2_host_pkg::*;

    localparam int IW = $clog2(INHIBIT_CYCLES + 1);

    typedef struct packed {
        tx_state_e     state;
        logic [IW-1:0] icnt;
        logic [3:0]    ecnt;
        logic [10:0]   sh;
        logic          done;
        logic          nack;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            TX_IDLE: begin
                if (start_i) begin
                    d.state = TX_INHIBIT;
                    d.icnt  = '0;
                    d.sh    = {1'b1, odd_par(byte_i), byte_i, 1'b0};
                end
            end
            TX_INHIBIT: begin
                if (q.icnt == IW'(INHIBIT_CYCLES - 1)) begin
                    d.state = TX_SHIFT;
                    d.ecnt  = '0;
                end else begin
                    d.icnt = q.icnt + IW'(1);
                end
            end
            TX_SHIFT: begin
                if (fall_i) begin
                    if (q.ecnt == 4'(FRAME_LAST)) begin
                        d.done  = 1'b1;
                        d.nack  = dat_i;
                        d.state = TX_IDLE;
                    end else begin
                        d.sh   = {1'b1, q.sh[10:1]};
                        d.ecnt = q.ecnt + 4'd1;
                    end
                end
            end
            default: d.state = TX_IDLE;
        endcase
        if (clr_i) begin
            d.state = TX_IDLE;
            d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= TX_IDLE;
            q.sh    <= '1;
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.state != TX_IDLE);
    assign clk_low_o  = (q.state == TX_INHIBIT);
    assign shifting_o = (q.state == TX_SHIFT);
    assign dat_low_o  = (q.state == TX_SHIFT) && !q.sh[0];
    assign done_o     = q.done;
    assign nack_o     = q.nack;

    // R8: shifting only begins after the full inhibit count
    p_tx_inhibit_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == TX_SHIFT && $past(q.state) == TX_INHIBIT)
        |-> ($past(q.icnt) == IW'(INHIBIT_CYCLES - 1)));
    // R8: a completed frame returns to idle
    p_tx_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.state == TX_IDLE));
endmodule

// File: rtl/ps2_host_port.sv
module ps2_host_port
    import ps2_host_pkg::*;
#(
    parameter int FILT_LEN       = 8,
    parameter int INHIBIT_CYCLES = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic       ps2_clk_oe_o,
    output logic       ps2_dat_oe_o,
    output logic       irq_o
);
    localparam int NLINES = 2;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] rx_data;
        logic       rx_full;
        logic       perr;
        logic       ferr;
        logic [7:0] tx_buf;
        logic       tx_full;
        logic       hold;
        logic       clk_prev;
    } port_t;

    port_t q, d;

    logic [NLINES-1:0] raw, filt;
    logic clk_filt, dat_filt, clk_fall;
    logic sreset, tx_start, rx_en, clk_oe;
    logic rx_busy, rx_done, rx_perr, rx_ferr;
    logic [7:0] rx_byte;
    logic tx_busy, tx_clk_low, tx_dat_low, tx_shifting, tx_done, tx_nack;
    logic [7:0] status;

    assign raw = {ps2_dat_i, ps2_clk_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        ps2_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (raw[g]),
            .level_o (filt[g])
        );
    end

    assign clk_filt = filt[0];
    assign dat_filt = filt[1];
    assign clk_fall = q.clk_prev & ~clk_filt;

    assign sreset   = q.ctrl[CTRL_SRST];
    assign tx_start = q.ctrl[CTRL_TXEN] & q.tx_full & ~tx_busy & ~rx_busy & ~sreset;
    assign clk_oe   = sreset | tx_clk_low | q.hold | (~q.ctrl[CTRL_RXCLK] & ~tx_busy);
    assign rx_en    = q.ctrl[CTRL_RXCLK] & ~clk_oe & ~tx_busy;

    ps2_rx_frame u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (sreset),
        .enable_i (rx_en),
        .fall_i   (clk_fall),
        .dat_i    (dat_filt),
        .busy_o   (rx_busy),
        .done_o   (rx_done),
        .byte_o   (rx_byte),
        .perr_o   (rx_perr),
        .ferr_o   (rx_ferr)
    );

    ps2_tx_frame #(.INHIBIT_CYCLES(INHIBIT_CYCLES)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (sreset),
        .start_i    (tx_start),
        .byte_i     (q.tx_buf),
        .fall_i     (clk_fall),
        .dat_i      (dat_filt),
        .busy_o     (tx_busy),
        .clk_low_o  (tx_clk_low),
        .dat_low_o  (tx_dat_low),
        .shifting_o (tx_shifting),
        .done_o     (tx_done),
        .nack_o     (tx_nack)
    );

    always_comb begin
        d          = q;
        d.clk_prev = clk_filt;
        if (reg_wr && reg_addr == ADDR_CTRL) d.ctrl = reg_wdata;
        if (reg_wr && reg_addr == ADDR_TXB && !q.tx_full && !sreset) begin
            d.tx_buf  = reg_wdata;
            d.tx_full = 1'b1;
        end
        if (tx_start) d.tx_full = 1'b0;
        if (reg_rd && reg_addr == ADDR_RXB) begin
            d.rx_full = 1'b0;
            d.perr    = 1'b0;
            d.ferr    = 1'b0;
        end
        if (rx_done) begin
            d.rx_data = rx_byte;
            d.rx_full = 1'b1;
            d.perr    = rx_perr;
            d.ferr    = rx_ferr;
        end
        if (tx_done) begin
            if (tx_nack) d.ferr = 1'b1;
            if (q.ctrl[CTRL_HOLD]) d.hold = 1'b1;
        end
        if (!q.ctrl[CTRL_HOLD] || tx_start) d.hold = 1'b0;
        if (sreset) begin
            d.rx_full = 1'b0;
            d.perr    = 1'b0;
            d.ferr    = 1'b0;
            d.tx_full = 1'b0;
            d.hold    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.clk_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign status = {q.ferr, q.perr, rx_busy, q.rx_full, ~q.tx_full, tx_busy, clk_oe, clk_filt};

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = q.ctrl;
            ADDR_STAT: reg_rdata = status;
            ADDR_TXB:  reg_rdata = q.tx_buf;
            default:   reg_rdata = q.rx_data;
        endcase
    end

    assign ps2_clk_oe_o = clk_oe;
    assign ps2_dat_oe_o = tx_dat_low;
    assign irq_o = (q.rx_full & q.ctrl[CTRL_RXIE])
                 | (~q.tx_full & q.ctrl[CTRL_TXIE] & q.ctrl[CTRL_TXEN]);

    // R7: a write while a byte is held leaves the held byte alone
    p_tx_buf_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_TXB && q.tx_full) |=> $stable(q.tx_buf));
    // R5: a receive read clears full and error flags
    p_rd_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_RXB && !rx_done && !tx_done && !sreset)
        |=> (!q.rx_full && !q.perr && !q.ferr));
    // R11: soft reset empties the buffers and errors
    p_sreset_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sreset |=> (!q.rx_full && !q.tx_full && !q.perr && !q.ferr && !q.hold));
    // R8: the clock is never pulled while the device clocks out a frame
    p_clk_free_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_shifting && !sreset) |-> !ps2_clk_oe_o);
endmodule

// File: tb/ps2_host_port_tb.sv
module ps2_host_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FILT = 3;
    localparam int INH  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd1;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic clk_oe, dat_oe, irq;
    logic dev_clk = 1'b1, dev_dat = 1'b1;
    logic clk_line, dat_line;

    int total = 0;
    int bad = 0;

    assign clk_line = dev_clk & ~clk_oe;
    assign dat_line = dev_dat & ~dat_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    ps2_host_port #(.FILT_LEN(FILT), .INHIBIT_CYCLES(INH)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .ps2_clk_i    (clk_line),
        .ps2_dat_i    (dat_line),
        .ps2_clk_oe_o (clk_oe),
        .ps2_dat_oe_o (dat_oe),
        .irq_o        (irq)
    );

    // {byte, flip parity, bad stop, expected status}
    localparam logic [17:0] VEC [6] = '{
        {8'hA5, 1'b0, 1'b0, 8'h19},
        {8'h00, 1'b0, 1'b0, 8'h19},
        {8'hFF, 1'b1, 1'b0, 8'h59},
        {8'h3C, 1'b0, 1'b1, 8'h99},
        {8'h81, 1'b1, 1'b1, 8'hD9},
        {8'h7E, 1'b0, 1'b0, 8'h19}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = 2'd1;
    endtask

    task automatic dev_send(input logic [7:0] b, input logic flip, input logic badstop,
                            input logic mid);
        logic [10:0] bits;
        bits = {~badstop, (~(^b)) ^ flip, b, 1'b0};
        for (int i = 0; i < 11; i++) begin
            dev_dat = bits[i];
            idle(8);
            dev_clk = 1'b0;
            idle(12);
            dev_clk = 1'b1;
            if (mid && i == 4) chk("R2 receive in progress", {7'd0, reg_rdata[5]}, 8'h01);
        end
        dev_dat = 1'b1;
    endtask

    task automatic dev_recv(input logic give_ack, output logic [7:0] b, output logic par_ok,
                            output logic stop_ok, output int ilen, output logic busy_seen,
                            output logic req_ok);
        logic [9:0] bits;
        while (!clk_oe) @(negedge clk);
        busy_seen = reg_rdata[2];
        ilen = 0;
        while (clk_oe) begin
            ilen++;
            @(negedge clk);
        end
        req_ok = dat_oe;
        for (int k = 1; k <= 11; k++) begin
            if (k == 11) dev_dat = ~give_ack;
            idle(8);
            dev_clk = 1'b0;
            idle(12);
            if (k <= 10) bits[k-1] = dat_line;
            dev_clk = 1'b1;
        end
        idle(6);
        dev_dat = 1'b1;
        b = bits[7:0];
        par_ok = (bits[8] == ~(^bits[7:0]));
        stop_ok = bits[9];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] b;
        logic par_ok, stop_ok, busy_seen, req_ok;
        int ilen;

        idle(3);
        rst_n = 1'b1;
        idle(20);
        // R1 reset state
        rd(2'd1, v); chk("R1 status after reset", v, 8'h0A);
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
        chk("R1 clock pulled", {6'd0, clk_oe, dat_oe}, 8'h02);
        rd(2'd0, v); chk("R1 control after reset", v, 8'h00);

        wr(2'd0, 8'h1A);
        idle(20);
        rd(2'd1, v); chk("R1 idle status enabled", v, 8'h09);

        // R2 R3 R4 R5 R12 receive table
        for (int n = 0; n < 6; n++) begin
            dev_send(VEC[n][17:10], VEC[n][9], VEC[n][8], n == 0);
            idle(20);
            rd(2'd1, v); chk("R2/R3/R4 status after frame", v, VEC[n][7:0]);
            chk("R12 rx irq", {7'd0, irq}, 8'h01);
            rd(2'd3, v); chk("R2 received byte", v, VEC[n][17:10]);
            rd(2'd1, v); chk("R5 status after read", v, 8'h09);
            chk("R12 irq after read", {7'd0, irq}, 8'h00);
        end

        // R6 receive clock disabled
        wr(2'd0, 8'h0A);
        idle(20);
        chk("R6 clock held", {7'd0, clk_oe}, 8'h01);
        rd(2'd1, v); chk("R6 status pull bit", {7'd0, v[1]}, 8'h01);
        dev_send(8'h55, 1'b0, 1'b0, 1'b0);
        idle(20);
        rd(2'd1, v); chk("R6 nothing received", {7'd0, v[4]}, 8'h00);

        // R9 transmit disabled, R7 ignored write
        wr(2'd0, 8'h18);
        idle(20);
        wr(2'd2, 8'h96);
        idle(60);
        rd(2'd1, v); chk("R9 held byte not sent", v, 8'h01);
        chk("R9 clock not pulled", {7'd0, clk_oe}, 8'h00);
        wr(2'd2, 8'h11);
        rd(2'd2, v); chk("R7 write while full ignored", v, 8'h96);

        // R8 transmission
        wr(2'd0, 8'h1A);
        dev_recv(1'b1, b, par_ok, stop_ok, ilen, busy_seen, req_ok);
        chk("R7 sent byte is first byte", b, 8'h96);
        chk("R8 parity odd", {7'd0, par_ok}, 8'h01);
        chk("R8 stop released", {7'd0, stop_ok}, 8'h01);
        chk("R8 inhibit long enough", {7'd0, ilen >= INH}, 8'h01);
        chk("R8 busy during transmit", {7'd0, busy_seen}, 8'h01);
        chk("R8 data low at release", {7'd0, req_ok}, 8'h01);
        idle(20);
        rd(2'd1, v); chk("R8 status after acked frame", v, 8'h09);

        // R4 missing acknowledge
        wr(2'd2, 8'h3C);
        dev_recv(1'b0, b, par_ok, stop_ok, ilen, busy_seen, req_ok);
        chk("R8 second byte", b, 8'h3C);
        idle(20);
        rd(2'd1, v); chk("R4 nack framing error", v, 8'h89);
        rd(2'd3, v);
        rd(2'd1, v); chk("R5 read clears nack error", v, 8'h09);

        // R10 hold after transmit
        wr(2'd0, 8'h1B);
        wr(2'd2, 8'hC3);
        dev_recv(1'b1, b, par_ok, stop_ok, ilen, busy_seen, req_ok);
        chk("R10 sent byte", b, 8'hC3);
        idle(20);
        chk("R10 clock held after send", {7'd0, clk_oe}, 8'h01);
        rd(2'd1, v); chk("R10 status pull bit", {7'd0, v[1]}, 8'h01);
        wr(2'd0, 8'h1A);
        idle(20);
        chk("R10 hold released", {7'd0, clk_oe}, 8'h00);

        // R12 transmit interrupt gating
        wr(2'd0, 8'h1E);
        idle(2);
        chk("R12 tx irq enabled", {7'd0, irq}, 8'h01);
        wr(2'd0, 8'h1C);
        idle(2);
        chk("R12 tx irq needs tx enable", {7'd0, irq}, 8'h00);

        // R11 soft reset
        wr(2'd0, 8'h18);
        idle(20);
        wr(2'd2, 8'h42);
        dev_send(8'h12, 1'b0, 1'b0, 1'b0);
        idle(20);
        rd(2'd1, v); chk("R11 setup full", v, 8'h11);
        wr(2'd0, 8'h21);
        idle(20);
        rd(2'd1, v); chk("R11 status during reset", v, 8'h0A);
        chk("R11 clock held", {7'd0, clk_oe}, 8'h01);
        wr(2'd0, 8'h1A);
        idle(60);
        rd(2'd1, v); chk("R11 nothing sent after reset", v, 8'h09);
        chk("R11 clock free", {7'd0, clk_oe}, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule